// File: doc/BRIEF.md
# Audio Data Burst Streamer

This block carries a byte stream from a host-side valid/ready port to the data input of an audio decoder over a serial link. It uses a clock line, a data line and an active-low data-select line. A request is opened with a start strobe and a byte count. The block then takes exactly that many bytes from the stream, through a small input FIFO, and shifts them out MSB first in SPI mode 0.

Flow control is done once per burst. A burst holds at most a fixed number of bytes, 32 by default. Before each burst the block waits for the device's ready input. Once the burst starts it does not look at that input again until the burst closes. Data-select is held low across the whole burst, including any gaps in the input stream, and goes high between bursts. When the request ends, a one-cycle done pulse is raised and the count of bytes shifted out is shown.

Top module: `bst_audio_streamer`

## Requirements
- R1: A request of N bytes goes out as ceil(N/BURST_MAX) bursts. Every burst before the last carries exactly BURST_MAX bytes (32 by default), and the last burst carries the rest.
- R2: Data-select falls only in the cycle after a clock edge at which dev_rdy_i was sampled high. A low dev_rdy_i during an open burst neither shortens nor pauses that burst.
- R3: dsel_n_o is low at every rising SCLK edge of a burst. It goes high after the last byte of each burst, stays high for at least one cycle between bursts, and is high whenever busy_o is low.
- R4: A start with len_i of zero shifts out no bytes. It raises done_o one cycle after the start, with sent_cnt_o equal to 0.
- R5: done_o is a pulse one cycle long. While it is high, sent_cnt_o equals the number of bytes shifted out, which is the requested length. The count then holds until the next accepted start.
- R6: The serial link runs in SPI mode 0. SCLK is low when idle, MOSI is stable at each rising edge, and each byte is sent MSB first. Each SCLK high phase lasts SCLK_DIV clock cycles (2 by default).
- R7: If the input stream stalls in the middle of a burst, data-select stays low and SCLK stays low until the next byte arrives.
- R8: s_ready_o is high only while a request is active and fewer than len_i of its bytes have been accepted. The block therefore takes exactly len_i bytes per request.
- R9: A start strobe is ignored while busy_o is high.
- R10: After reset, dsel_n_o is 1 and sclk_o, done_o, busy_o, s_ready_o and sent_cnt_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a request when idle |
| len_i | input | LEN_W | Byte count of the request, sampled with start_i |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_ready_o | output | 1 | Stream byte accepted when high together with s_valid_i |
| dev_rdy_i | input | 1 | Device can take a burst |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data, MSB first |
| dsel_n_o | output | 1 | Active-low data select, framing one burst |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle pulse at request end |
| sent_cnt_o | output | LEN_W | Bytes shifted out in the latest request |

## Verification
Two things can land in the same cycle. The shifter can finish a byte in the cycle where the burst counter reaches its limit, or where a late stream byte is popped from the FIFO. The bench provokes this with random gaps on s_valid_i and with lengths on either side of 32. It then checks that every burst has the expected size and that data-select never opens a burst without a sampled ready. A second collision comes from dropping dev_rdy_i in the same cycle a burst opens, and from holding it low for a whole burst. Each closed burst is judged by its byte count, and the byte order is checked against the source bytes.

// File: rtl/bst_pkg.sv
package bst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_RDY = 2'd1,
        ST_BURST    = 2'd2,
        ST_GAP      = 2'd3
    } bst_state_e;

endpackage

// File: rtl/bst_in_fifo.sv
module bst_in_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] din_i,
    output logic          full_o,
    input  logic          pop_i,
    output logic [DW-1:0] dout_o,
    output logic          empty_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW:0]              wr;
        logic [AW:0]              rd;
    } fifo_t;

    fifo_t q, d;

    always_comb begin
        d = q;
        if (push_i && !full_o) begin
            d.mem[q.wr[AW-1:0]] = din_i;
            d.wr = q.wr + 1'b1;
        end
        if (pop_i && !empty_o) begin
            d.rd = q.rd + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign empty_o = (q.wr == q.rd);
    assign full_o  = (q.wr[AW] != q.rd[AW]) && (q.wr[AW-1:0] == q.rd[AW-1:0]);
    assign dout_o  = q.mem[q.rd[AW-1:0]];

endmodule

// File: rtl/bst_spi_shift.sv
module bst_spi_shift #(
    parameter int DW  = 8,
    parameter int DIV = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          sclk_o,
    output logic          mosi_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int FW = $clog2(DW);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic          sclk;
        logic [DW-1:0] sh;
        logic [FW-1:0] falls;
        logic [CW-1:0] div;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (load_i) begin
                d.busy  = 1'b1;
                d.sh    = data_i;
                d.falls = '0;
                d.div   = '0;
                d.sclk  = 1'b0;
            end
        end else if (q.div == CW'(DIV - 1)) begin
            d.div  = '0;
            d.sclk = ~q.sclk;
            if (q.sclk) begin
                d.sh    = {q.sh[DW-2:0], 1'b0};
                d.falls = q.falls + 1'b1;
                if (q.falls == FW'(DW - 1)) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end
            end
        end else begin
            d.div = q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o = q.busy;
    assign done_o = q.done;
    assign sclk_o = q.sclk;
    assign mosi_o = q.sh[DW-1];

endmodule

// File: rtl/bst_burst_ctrl.sv
module bst_burst_ctrl
    import bst_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int BURST_MAX = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             dev_rdy_i,
    input  logic             push_i,
    input  logic             fifo_empty_i,
    input  logic             shift_busy_i,
    input  logic             shift_done_i,
    output logic             take_ok_o,
    output logic             pop_o,
    output logic             dsel_n_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [LEN_W-1:0] sent_cnt_o
);
    localparam int BW = $clog2(BURST_MAX + 1);

    typedef struct packed {
        bst_state_e       st;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] taken;
        logic [LEN_W-1:0] issued;
        logic [LEN_W-1:0] sent;
        logic [BW-1:0]    burst_n;
        logic             dsel_n;
        logic             done;
    } ctrl_t;

    ctrl_t q, d;
    logic  burst_full;
    logic  all_issued;

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        pop_o      = 1'b0;
        burst_full = (q.burst_n == BW'(BURST_MAX));
        all_issued = (q.issued == q.len);
        if (push_i) begin
            d.taken = q.taken + 1'b1;
        end
        if (shift_done_i) begin
            d.sent = q.sent + 1'b1;
        end
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.len    = len_i;
                    d.taken  = '0;
                    d.issued = '0;
                    d.sent   = '0;
                    if (len_i == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.st = ST_WAIT_RDY;
                    end
                end
            end
            ST_WAIT_RDY: begin
                if (dev_rdy_i) begin
                    d.st      = ST_BURST;
                    d.dsel_n  = 1'b0;
                    d.burst_n = '0;
                end
            end
            ST_BURST: begin
                if (!shift_busy_i && !fifo_empty_i && !burst_full && !all_issued) begin
                    pop_o     = 1'b1;
                    d.issued  = q.issued + 1'b1;
                    d.burst_n = q.burst_n + 1'b1;
                end else if (!shift_busy_i && (burst_full || all_issued)) begin
                    d.st     = ST_GAP;
                    d.dsel_n = 1'b1;
                end
            end
            ST_GAP: begin
                if (all_issued) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.st = ST_WAIT_RDY;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.dsel_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign take_ok_o  = (q.st != ST_IDLE) && (q.taken != q.len);
    assign dsel_n_o   = q.dsel_n;
    assign busy_o     = (q.st != ST_IDLE);
    assign done_o     = q.done;
    assign sent_cnt_o = q.sent;

endmodule

// File: rtl/bst_audio_streamer.sv
module bst_audio_streamer #(
    parameter int LEN_W      = 16,
    parameter int BURST_MAX  = 32,
    parameter int FIFO_DEPTH = 4,
    parameter int SCLK_DIV   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             s_valid_i,
    input  logic [7:0]       s_data_i,
    output logic             s_ready_o,
    input  logic             dev_rdy_i,
    output logic             sclk_o,
    output logic             mosi_o,
    output logic             dsel_n_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [LEN_W-1:0] sent_cnt_o
);
    localparam int DW = 8;

    logic          take_ok;
    logic          push;
    logic          pop;
    logic          fifo_full;
    logic          fifo_empty;
    logic [DW-1:0] fifo_dout;
    logic          sh_busy;
    logic          sh_done;

    assign s_ready_o = take_ok && !fifo_full;
    assign push      = s_valid_i && s_ready_o;

    bst_in_fifo #(
        .DW    (DW),
        .DEPTH (FIFO_DEPTH)
    ) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .din_i   (s_data_i),
        .full_o  (fifo_full),
        .pop_i   (pop),
        .dout_o  (fifo_dout),
        .empty_o (fifo_empty)
    );

    bst_spi_shift #(
        .DW  (DW),
        .DIV (SCLK_DIV)
    ) shift_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (pop),
        .data_i (fifo_dout),
        .busy_o (sh_busy),
        .done_o (sh_done),
        .sclk_o (sclk_o),
        .mosi_o (mosi_o)
    );

    bst_burst_ctrl #(
        .LEN_W     (LEN_W),
        .BURST_MAX (BURST_MAX)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .len_i        (len_i),
        .dev_rdy_i    (dev_rdy_i),
        .push_i       (push),
        .fifo_empty_i (fifo_empty),
        .shift_busy_i (sh_busy),
        .shift_done_i (sh_done),
        .take_ok_o    (take_ok),
        .pop_o        (pop),
        .dsel_n_o     (dsel_n_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .sent_cnt_o   (sent_cnt_o)
    );

endmodule

// File: rtl/bst_streamer_chk.sv
module bst_streamer_chk #(
    parameter int LEN_W     = 16,
    parameter int BURST_MAX = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [LEN_W-1:0] len_i,
    input logic             dev_rdy_i,
    input logic             s_ready_o,
    input logic             sclk_o,
    input logic             dsel_n_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [LEN_W-1:0] sent_cnt_o
);
    localparam int CNTW = $clog2(8 * BURST_MAX + 2);

    logic            sclk_p;
    logic [CNTW-1:0] rise_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_p   <= 1'b0;
            rise_cnt <= '0;
        end else begin
            sclk_p <= sclk_o;
            if (dsel_n_o) begin
                rise_cnt <= '0;
            end else if (sclk_o && !sclk_p) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    p_burst_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_cnt <= CNTW'(8 * BURST_MAX));

    p_open_on_rdy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dsel_n_o) |-> $past(dev_rdy_i));

    p_dsel_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> dsel_n_o);

    p_zero_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && len_i == '0) |=> (done_o && sent_cnt_o == '0));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(sent_cnt_o));

    p_sclk_framed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dsel_n_o |-> !sclk_o);

    p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !s_ready_o);

endmodule

bind bst_audio_streamer bst_streamer_chk #(
    .LEN_W     (LEN_W),
    .BURST_MAX (BURST_MAX)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .len_i      (len_i),
    .dev_rdy_i  (dev_rdy_i),
    .s_ready_o  (s_ready_o),
    .sclk_o     (sclk_o),
    .dsel_n_o   (dsel_n_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .sent_cnt_o (sent_cnt_o)
);

// File: tb/bst_audio_streamer_tb_top.sv
module bst_audio_streamer_tb_top;
    localparam int LEN_W = 16;
    localparam int BMAX  = 32;
    localparam int DIV   = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [LEN_W-1:0] len_i = '0;
    logic             s_valid_i = 1'b0;
    logic [7:0]       s_data_i = '0;
    logic             s_ready_o;
    logic             dev_rdy_i = 1'b1;
    logic             sclk_o;
    logic             mosi_o;
    logic             dsel_n_o;
    logic             busy_o;
    logic             done_o;
    logic [LEN_W-1:0] sent_cnt_o;

    bst_audio_streamer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .len_i      (len_i),
        .s_valid_i  (s_valid_i),
        .s_data_i   (s_data_i),
        .s_ready_o  (s_ready_o),
        .dev_rdy_i  (dev_rdy_i),
        .sclk_o     (sclk_o),
        .mosi_o     (mosi_o),
        .dsel_n_o   (dsel_n_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .sent_cnt_o (sent_cnt_o)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int exp_burst(input int len, input int idx);
        int rest;
        rest = len - idx * BMAX;
        return (rest >= BMAX) ? BMAX : rest;
    endfunction

    function automatic int exp_nbursts(input int len);
        return (len + BMAX - 1) / BMAX;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_errors++;
            $display("FAIL R5 watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    // rdy_mode: 0 random, 1 forced low, 2 forced high
    int rdy_mode = 2;
    always @(negedge clk) begin
        case (rdy_mode)
            0: dev_rdy_i <= ($urandom % 100) < 70;
            1: dev_rdy_i <= 1'b0;
            default: dev_rdy_i <= 1'b1;
        endcase
    end

    logic rdy_s = 1'b0;
    always @(posedge clk) rdy_s <= dev_rdy_i;

    // reference monitor
    logic [7:0] exp_q[$];
    logic [7:0] src[$];
    int   cur_len = 0;
    int   burst_idx = 0;
    int   burst_bytes = 0;
    int   rx_total = 0;
    int   bits = 0;
    int   hi_len = 0;
    bit   done_seen = 0;
    logic [7:0] shreg = '0;
    logic sclk_p = 1'b0;
    logic dsel_p = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk_o && !sclk_p) begin
                check(dsel_n_o == 1'b0, "R3 dsel low at sclk rise", dsel_n_o, 0);
                shreg = {shreg[6:0], mosi_o};
                bits++;
                if (bits == 8) begin
                    bits = 0;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R6 unexpected byte", shreg, -1);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        check(shreg == e, "R6 byte value msb first", shreg, e);
                    end
                    burst_bytes++;
                    rx_total++;
                end
            end
            if (sclk_o) begin
                hi_len++;
            end else if (sclk_p) begin
                check(hi_len == DIV, "R6 sclk high phase", hi_len, DIV);
                hi_len = 0;
            end
            if (!dsel_n_o && dsel_p) begin
                check(rdy_s == 1'b1, "R2 burst opened without ready", rdy_s, 1);
                burst_bytes = 0;
            end
            if (dsel_n_o && !dsel_p) begin
                check(burst_bytes == exp_burst(cur_len, burst_idx), "R1 burst size",
                      burst_bytes, exp_burst(cur_len, burst_idx));
                check(bits == 0, "R3 dsel rose mid byte", bits, 0);
                burst_idx++;
            end
            if (done_o) begin
                check(int'(sent_cnt_o) == cur_len, "R5 count at done", sent_cnt_o, cur_len);
                check(rx_total == cur_len, "R5 bytes seen at done", rx_total, cur_len);
                check(burst_idx == exp_nbursts(cur_len), "R1 burst count",
                      burst_idx, exp_nbursts(cur_len));
                done_seen = 1;
            end
            sclk_p = sclk_o;
            dsel_p = dsel_n_o;
        end
    end

    task automatic run_req(input int len, input int gap_pct, input int stall_at, input bit inject);
        int i;
        int k;
        bit stalled;
        src.delete();
        for (int j = 0; j < len; j++) begin
            logic [7:0] b;
            b = 8'($urandom);
            src.push_back(b);
            exp_q.push_back(b);
        end
        cur_len   = len;
        burst_idx = 0;
        rx_total  = 0;
        done_seen = 0;
        @(negedge clk);
        start_i = 1'b1;
        len_i   = LEN_W'(len);
        @(negedge clk);
        start_i = 1'b0;
        i = 0;
        k = 0;
        stalled = 0;
        while (i < len) begin
            if (i == stall_at && !stalled) begin
                s_valid_i = 1'b0;
                repeat (200) @(negedge clk);
                check(dsel_n_o == 1'b0, "R7 dsel held low in stall", dsel_n_o, 0);
                check(sclk_o == 1'b0, "R7 sclk parked in stall", sclk_o, 0);
                stalled = 1;
            end
            start_i   = inject && (k == 20);
            len_i     = inject && (k == 20) ? LEN_W'(3) : LEN_W'(len);
            s_valid_i = ($urandom % 100) >= gap_pct;
            s_data_i  = src[i];
            #1;
            if (s_valid_i && s_ready_o) i++;
            k++;
            @(negedge clk);
        end
        s_valid_i = 1'b0;
        start_i   = 1'b0;
        #1;
        if (len > 0) check(s_ready_o == 1'b0, "R8 ready after len taken", s_ready_o, 0);
        while (!done_seen) @(negedge clk);
        check(exp_q.size() == 0, "R6 all bytes delivered", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(dsel_n_o == 1'b1, "R10 dsel reset", dsel_n_o, 1);
        check(sclk_o == 1'b0, "R10 sclk reset", sclk_o, 0);
        check(done_o == 1'b0 && busy_o == 1'b0, "R10 done/busy reset", done_o + busy_o, 0);
        check(s_ready_o == 1'b0, "R10 ready reset", s_ready_o, 0);
        check(sent_cnt_o == '0, "R10 count reset", sent_cnt_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4 zero length
        cur_len = 0; burst_idx = 0; rx_total = 0; done_seen = 0;
        start_i = 1'b1; len_i = '0;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o == 1'b1, "R4 done one cycle after zero start", done_o, 1);
        check(sent_cnt_o == '0, "R4 zero count", sent_cnt_o, 0);
        check(dsel_n_o == 1'b1, "R4 no burst", dsel_n_o, 1);
        repeat (3) @(negedge clk);

        // directed lengths around the burst limit
        run_req(1, 0, -1, 0);
        run_req(31, 20, -1, 0);
        run_req(32, 0, -1, 0);
        run_req(33, 30, -1, 0);
        run_req(64, 10, -1, 0);

        // R8 idle stream must not be taken
        s_valid_i = 1'b1;
        repeat (10) begin
            @(negedge clk);
            check(s_ready_o == 1'b0, "R8 ready low when idle", s_ready_o, 0);
        end
        s_valid_i = 1'b0;
        check(int'(sent_cnt_o) == 64, "R5 count holds after done", sent_cnt_o, 64);

        // R2 ready held low: no burst opens
        rdy_mode = 1;
        fork
            run_req(10, 0, -1, 0);
            begin
                repeat (60) @(negedge clk);
                check(dsel_n_o == 1'b1, "R2 no burst while not ready", dsel_n_o, 1);
                rdy_mode = 2;
            end
        join

        // R2 ready dropped just as the burst opens: burst still full
        fork
            run_req(40, 0, -1, 0);
            begin
                @(negedge dsel_n_o);
                rdy_mode = 1;
                repeat (600) @(negedge clk);
                rdy_mode = 2;
            end
        join

        // R7 stall mid burst
        run_req(40, 0, 10, 0);

        // R9 start while busy
        run_req(50, 10, -1, 1);
        check(int'(sent_cnt_o) == 50, "R9 start ignored while busy", sent_cnt_o, 50);

        // random requests
        rdy_mode = 0;
        for (int r = 0; r < 6; r++) begin
            run_req(1 + int'($urandom % 90), int'($urandom % 60), -1, 0);
        end
        rdy_mode = 2;

        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end

endmodule